// File: doc/BRIEF.md
# HDLC Frame Receiver with Length and FCS Validation

This block turns a serial bit stream, qualified by a per-bit enable, back into HDLC frames. It hunts for the 01111110 flag, removes the zero inserted after every run of five ones, and runs a CRC-16 over the recovered bits. At the closing flag it sorts the frame by length and check result. Surviving bytes go into a 16-entry receive queue. Each byte carries a two-bit tag that marks it as the opening byte, a middle byte, a good final byte or a bad final byte.

The two frame check bytes are never stored. Recovered bytes wait in a three-byte hold stage until the frame ends. Only then is it known which byte was the last data byte and which bytes were check bytes. The same bit-level logic also reports two link conditions: a one-cycle go-ahead pulse, and a level that shows an idle channel after a long run of ones. Software or a downstream engine drains the queue through a first-word-fall-through read port.

Top module: `hdlc_frame_rx`

## Requirements
- R1: Bits that arrive before the first 01111110 flag are not decoded, and no queue entry results from them.
- R2: Inside a frame, a 0 that follows five consecutive 1s is removed, so payload bytes that contain runs of ones come out intact.
- R3: A frame with fewer than 25 de-stuffed bits between its flags writes nothing to the queue.
- R4: A frame with 25 to 31 de-stuffed bits writes its first three bytes with tags 01, 00 and 11. Any trailing partial byte is dropped.
- R5: A frame of at least 32 bits whose CRC over data plus check bytes leaves the residue 0xF0B8, and whose length is a whole number of bytes, is written without its two check bytes. Its tags are 01 on the first byte, 00 on middle bytes and 10 on the last data byte (tag = rd_stat, 2 bits).
- R6: A frame of at least 32 bits with a wrong residue, or with a length that is not a whole number of bytes, is written the same way except that its last data byte is tagged 11.
- R7: Seven consecutive 1s inside a frame abort it, and trailing ones of the data count toward the seven. If at least 26 bits had been recovered, the three held bytes are written with the last one tagged 11 (and the first tagged 01 if no byte of the frame was written yet). A shorter aborted frame writes nothing.
- R8: go_ahead pulses high for exactly one cycle after the bit that completes 011111110. It stays low during ordinary flagged frames.
- R9: idle_line goes high once 15 consecutive 1s have been received, stays high while ones continue, and drops after the next received 0.
- R10: The queue holds 16 entries. A write to a full queue is discarded and sets fifo_ovf, which stays set until reset.
- R11: While rx_en is low every bit is ignored, any frame in progress is dropped, and the ones count is cleared.
- R12: Cycles with bit_vld low change no receive state, so a frame spread over idle cycles decodes the same as a dense one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable |
| bit_vld | input | 1 | Qualifies bit_in for this cycle |
| bit_in | input | 1 | Serial line bit |
| rd_en | input | 1 | Pops the head entry when the queue is not empty |
| rd_byte | output | 8 | Data byte at the head of the queue |
| rd_stat | output | 2 | Tag of the head entry: 00 middle, 01 first, 10 good end, 11 bad end |
| rd_empty | output | 1 | Queue holds no entry |
| fifo_ovf | output | 1 | Sticky overflow indication |
| go_ahead | output | 1 | One-cycle go-ahead pulse |
| idle_line | output | 1 | Idle channel indication |

## Verification
Say a bit is accepted on clock edge E. The go_ahead and idle_line results are registered once, so they are valid in the cycle after E. A byte completed in the middle of a frame reaches the queue on edge E+2. The entries written when a frame ends land on edges E+3 through E+5, one per cycle, counted from the edge that accepts the last flag bit. The bench therefore samples the link indications on the falling edge right after the accepting edge, and waits ten cycles after a frame before it reads the queue. All queue reads and output checks are taken on falling edges.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    localparam int BYTE_W = 8;
    localparam int STAT_W = 2;
    localparam int WORD_W = BYTE_W + STAT_W;

    typedef enum logic [STAT_W-1:0] {
        ST_MID      = 2'b00,
        ST_FIRST    = 2'b01,
        ST_GOOD_END = 2'b10,
        ST_BAD_END  = 2'b11
    } rx_stat_e;

    localparam logic [15:0] CRC_INIT    = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_R  = 16'h8408;
    localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;

    // one line event per accepted bit, produced by the bit stage
    typedef struct packed {
        logic vld;      // de-stuffed data bit leaves the flag delay
        logic bit_val;
        logic open;     // flag seen: a frame starts
        logic close;    // flag seen while a frame was open
        logic abort;    // seven ones inside a frame
    } line_evt_t;

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        crc_step = (c >> 1) ^ (fb ? CRC_POLY_R : 16'h0000);
    endfunction

endpackage

// File: rtl/hdlc_rx_line.sv
module hdlc_rx_line
    import hdlc_rx_pkg::*;
#(
    parameter int IDLE_ONES = 15
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rx_en,
    input  logic      bit_vld,
    input  logic      bit_in,
    output line_evt_t evt,
    output logic      go_ahead,
    output logic      idle
);

    localparam int FLAG_LEN   = 8;
    localparam int DLY        = FLAG_LEN - 1;
    localparam int HIST_W     = FLAG_LEN + 1;
    localparam int STUFF_ONES = 5;
    localparam int ABORT_ONES = 7;
    localparam int ONES_W     = $clog2(IDLE_ONES + 1);
    localparam int FILL_W     = $clog2(DLY + 1);
    localparam logic [FLAG_LEN-1:0] FLAG_PAT = 8'b01111110;
    localparam logic [HIST_W-1:0]   GA_PAT   = 9'b011111110;

    typedef struct packed {
        logic [ONES_W-1:0] ones;
        logic [HIST_W-1:0] hist;
        logic              in_frame;
        logic [DLY-1:0]    dly;
        logic [FILL_W-1:0] fill;
        line_evt_t         evt;
        logic              ga;
    } line_state_t;

    line_state_t q, d;

    always_comb begin
        logic [HIST_W-1:0] hist_n;
        d        = q;
        d.evt    = '0;
        d.ga     = 1'b0;
        hist_n   = {q.hist[HIST_W-2:0], bit_in};
        if (!rx_en) begin
            d.ones     = '0;
            d.hist     = '0;
            d.in_frame = 1'b0;
            d.fill     = '0;
        end else if (bit_vld) begin
            d.hist = hist_n;
            if (bit_in) begin
                d.ones = (q.ones == ONES_W'(IDLE_ONES)) ? q.ones : q.ones + ONES_W'(1);
            end else begin
                d.ones = '0;
            end
            d.ga = (hist_n == GA_PAT);
            if (hist_n[FLAG_LEN-1:0] == FLAG_PAT) begin
                d.evt.close = q.in_frame;
                d.evt.open  = 1'b1;
                d.in_frame  = 1'b1;
                d.fill      = '0;
            end else if (q.in_frame && bit_in && q.ones == ONES_W'(ABORT_ONES - 1)) begin
                d.evt.abort = 1'b1;
                d.in_frame  = 1'b0;
            end else if (q.in_frame && !bit_in && q.ones == ONES_W'(STUFF_ONES)) begin
                d.dly = q.dly;  // inserted zero: dropped
            end else if (q.in_frame) begin
                d.dly = {q.dly[DLY-2:0], bit_in};
                if (q.fill == FILL_W'(DLY)) begin
                    d.evt.vld     = 1'b1;
                    d.evt.bit_val = q.dly[DLY-1];
                end else begin
                    d.fill = q.fill + FILL_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign evt      = q.evt;
    assign go_ahead = q.ga;
    assign idle     = (q.ones == ONES_W'(IDLE_ONES));

    AST_GA_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        go_ahead |=> !go_ahead);  // R8
    AST_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && bit_vld && !bit_in) |=> !idle);  // R9
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (evt == '0 && !idle));  // R11
    AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && !bit_vld) |=> ($stable(q.ones) && $stable(q.in_frame) && $stable(q.fill)));  // R12

endmodule

// File: rtl/hdlc_rx_pack.sv
module hdlc_rx_pack
    import hdlc_rx_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int MIN_KEEP  = 25,
    parameter int MIN_GOOD  = 32,
    parameter int MIN_ABORT = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  line_evt_t         evt,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_word
);

    localparam int FCS_BYTES = 2;
    localparam int HOLD      = FCS_BYTES + 1;
    localparam int HC_W      = $clog2(HOLD + 1);
    localparam int BC_W      = $clog2(BYTE_W);

    typedef struct packed {
        logic [LEN_W-1:0]              len;
        logic [15:0]                   crc;
        logic [BYTE_W-1:0]             sr;
        logic [BC_W-1:0]               bcnt;
        logic [HOLD-1:0][BYTE_W-1:0]   hold;
        logic [HC_W-1:0]               hcnt;
        logic                          first_done;
        logic [HOLD-1:0][WORD_W-1:0]   dq;
        logic [HC_W-1:0]               dcnt;
        logic                          wr;
        logic [WORD_W-1:0]             wword;
    } pack_state_t;

    pack_state_t q, d;

    logic byte_push;
    assign byte_push = evt.vld && (q.bcnt == BC_W'(BYTE_W - 1)) && (q.hcnt == HC_W'(HOLD));

    always_comb begin
        logic [BYTE_W-1:0] byte_n;
        logic              flush_all;
        logic              good_end;
        logic              fcs_ok;
        rx_stat_e          st;
        d         = q;
        d.wr      = 1'b0;
        byte_n    = {evt.bit_val, q.sr[BYTE_W-1:1]};
        st        = ST_MID;
        flush_all = (evt.abort && q.len >= LEN_W'(MIN_ABORT))
                 || (evt.close && q.len >= LEN_W'(MIN_KEEP) && q.len < LEN_W'(MIN_GOOD));
        good_end  = evt.close && q.len >= LEN_W'(MIN_GOOD);
        fcs_ok    = (q.crc == CRC_RESIDUE) && (q.bcnt == '0);

        // end-of-frame entries leave one per cycle
        if (q.dcnt != '0) begin
            d.wr    = 1'b1;
            d.wword = q.dq[0];
            for (int i = 0; i < HOLD - 1; i++) begin
                d.dq[i] = q.dq[i+1];
            end
            d.dq[HOLD-1] = '0;
            d.dcnt       = q.dcnt - HC_W'(1);
        end

        if (evt.vld) begin
            if (q.len != '1) begin
                d.len = q.len + LEN_W'(1);
            end
            d.crc  = crc_step(q.crc, evt.bit_val);
            d.sr   = byte_n;
            d.bcnt = q.bcnt + BC_W'(1);
            if (q.bcnt == BC_W'(BYTE_W - 1)) begin
                if (q.hcnt == HC_W'(HOLD)) begin
                    d.wr         = 1'b1;
                    d.wword      = {(q.first_done ? ST_MID : ST_FIRST), q.hold[0]};
                    d.first_done = 1'b1;
                    for (int i = 0; i < HOLD - 1; i++) begin
                        d.hold[i] = q.hold[i+1];
                    end
                    d.hold[HOLD-1] = byte_n;
                end else begin
                    d.hold[q.hcnt] = byte_n;
                    d.hcnt         = q.hcnt + HC_W'(1);
                end
            end
        end

        if (flush_all) begin
            for (int i = 0; i < HOLD; i++) begin
                if (i == 0 && !q.first_done) begin
                    st = ST_FIRST;
                end else if (i == HOLD - 1) begin
                    st = ST_BAD_END;
                end else begin
                    st = ST_MID;
                end
                d.dq[i] = {st, q.hold[i]};
            end
            d.dcnt = HC_W'(HOLD);
        end else if (good_end) begin
            d.dq[0] = {(fcs_ok ? ST_GOOD_END : ST_BAD_END), q.hold[0]};
            d.dcnt  = HC_W'(1);
        end

        if (evt.open || evt.close || evt.abort) begin
            d.len        = '0;
            d.crc        = CRC_INIT;
            d.bcnt       = '0;
            d.hcnt       = '0;
            d.first_done = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.crc <= CRC_INIT;
        end else begin
            q <= d;
        end
    end

    assign wr_en   = q.wr;
    assign wr_word = q.wword;

    AST_END_THEN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_word[WORD_W-1]) |=> !wr_en);  // R5
    AST_DRAIN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.close || evt.abort) |-> (q.dcnt == '0));  // R4
    AST_HOLD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.close && q.len >= LEN_W'(MIN_KEEP)) |-> (q.hcnt == HC_W'(HOLD)));  // R4
    AST_SHORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.close && q.len < LEN_W'(MIN_KEEP) && q.dcnt == '0) |=> (q.dcnt == '0 && !wr_en));  // R3
    AST_NO_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (q.dcnt != '0) |-> !byte_push);  // R7

endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_word,
    input  logic         rd_en,
    output logic [W-1:0] rd_word,
    output logic         empty,
    output logic         ovf
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
        logic          ovf;
    } fifo_state_t;

    fifo_state_t q, d;
    logic [W-1:0] mem [DEPTH];
    logic full, do_wr, do_rd;

    assign full  = (q.cnt == CW'(DEPTH));
    assign do_wr = wr_en && !full;
    assign do_rd = rd_en && (q.cnt != '0);

    always_comb begin
        d = q;
        if (do_wr) begin
            d.wptr = (q.wptr == AW'(DEPTH - 1)) ? '0 : q.wptr + AW'(1);
        end
        if (do_rd) begin
            d.rptr = (q.rptr == AW'(DEPTH - 1)) ? '0 : q.rptr + AW'(1);
        end
        case ({do_wr, do_rd})
            2'b10:   d.cnt = q.cnt + CW'(1);
            2'b01:   d.cnt = q.cnt - CW'(1);
            default: d.cnt = q.cnt;
        endcase
        d.ovf = q.ovf | (wr_en && full);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[q.wptr] <= wr_word;
        end
    end

    assign rd_word = mem[q.rptr];
    assign empty   = (q.cnt == '0);
    assign ovf     = q.ovf;

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);  // R10
    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));  // R10
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en) |=> (full && ovf));  // R10

endmodule

// File: rtl/hdlc_frame_rx.sv
module hdlc_frame_rx
    import hdlc_rx_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int IDLE_ONES = 15,
    parameter int LEN_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [STAT_W-1:0] rd_stat,
    output logic              rd_empty,
    output logic              fifo_ovf,
    output logic              go_ahead,
    output logic              idle_line
);

    line_evt_t         evt;
    logic              wr_en;
    logic [WORD_W-1:0] wr_word;
    logic [WORD_W-1:0] rd_word;

    hdlc_rx_line #(.IDLE_ONES(IDLE_ONES)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_en    (rx_en),
        .bit_vld  (bit_vld),
        .bit_in   (bit_in),
        .evt      (evt),
        .go_ahead (go_ahead),
        .idle     (idle_line)
    );

    hdlc_rx_pack #(.LEN_W(LEN_W)) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .wr_en   (wr_en),
        .wr_word (wr_word)
    );

    hdlc_rx_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_word (wr_word),
        .rd_en   (rd_en),
        .rd_word (rd_word),
        .empty   (rd_empty),
        .ovf     (fifo_ovf)
    );

    assign rd_byte = rd_word[BYTE_W-1:0];
    assign rd_stat = rd_word[WORD_W-1:BYTE_W];

endmodule

// File: tb/hdlc_frame_rx_tb.sv
module hdlc_frame_rx_tb;

    logic clk = 1'b0;
    logic rst_n, rx_en, bit_vld, bit_in, rd_en;
    logic [7:0] rd_byte;
    logic [1:0] rd_stat;
    logic rd_empty, fifo_ovf, go_ahead, idle_line;

    int n_checks = 0;
    int n_fail   = 0;
    int ga_cnt   = 0;
    int tb_ones  = 0;
    logic [7:0] pay [24];

    always #10 clk = ~clk;

    hdlc_frame_rx u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .bit_vld(bit_vld), .bit_in(bit_in),
        .rd_en(rd_en), .rd_byte(rd_byte), .rd_stat(rd_stat), .rd_empty(rd_empty),
        .fifo_ovf(fifo_ovf), .go_ahead(go_ahead), .idle_line(idle_line)
    );

    always @(negedge clk) begin
        if (rst_n && go_ahead) ga_cnt++;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic b);
        logic [15:0] r;
        r = {1'b0, c[15:1]};
        if (c[0] != b) r = r ^ 16'h8408;  // x^16+x^12+x^5+1, reflected
        return r;
    endfunction

    task automatic send_raw(input logic b);
        @(negedge clk);
        bit_in  = b;
        bit_vld = 1'b1;
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    task automatic send_stuffed(input logic b);
        send_raw(b);
        tb_ones = b ? tb_ones + 1 : 0;
        if (tb_ones == 5) begin
            send_raw(1'b0);
            tb_ones = 0;
        end
    endtask

    task automatic send_flag();
        send_raw(1'b0);
        for (int i = 0; i < 6; i++) send_raw(1'b1);
        send_raw(1'b0);
        tb_ones = 0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_stuffed(v[i]);
    endtask

    task automatic settle();
        repeat (10) @(negedge clk);
    endtask

    // frame of n payload bytes, check bytes appended, closing flag
    task automatic send_frame(input int n, input logic corrupt, input int gap);
        logic [15:0] c;
        c = 16'hFFFF;
        send_flag();
        for (int i = 0; i < n; i++) begin
            send_byte(pay[i]);
            for (int k = 0; k < 8; k++) c = crc_bit(c, pay[i][k]);
            if (i == 0 && gap > 0) begin
                repeat (gap) @(negedge clk) bit_in = ~bit_in;
            end
        end
        c = ~c;
        if (corrupt) c[0] = ~c[0];
        send_byte(c[7:0]);
        send_byte(c[15:8]);
        send_flag();
    endtask

    task automatic pop_expect(input string tag, input logic [7:0] b, input logic [1:0] s);
        @(negedge clk);
        check({tag, " not empty"}, {31'd0, rd_empty}, 32'd0);
        check({tag, " entry"}, {22'd0, rd_stat, rd_byte}, {22'd0, s, b});
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic expect_empty(input string tag);
        @(negedge clk);
        check({tag, " empty"}, {31'd0, rd_empty}, 32'd1);
    endtask

    task automatic t_reset();
        check("R10 reset empty", {31'd0, rd_empty}, 32'd1);
        check("R10 reset ovf", {31'd0, fifo_ovf}, 32'd0);
        check("R9 reset idle", {31'd0, idle_line}, 32'd0);
        check("R8 reset go_ahead", {31'd0, go_ahead}, 32'd0);
    endtask

    task automatic t_pre_flag();  // R1
        send_byte(8'h12); send_byte(8'h34); send_byte(8'h56);
        send_byte(8'h78); send_byte(8'h9A);
        settle();
        expect_empty("R1 no flag");
    endtask

    task automatic t_good();  // R5, R8 (no pulse in frames)
        int ga0;
        ga0 = ga_cnt;
        pay[0] = 8'h12; pay[1] = 8'h34; pay[2] = 8'h56;
        send_frame(3, 1'b0, 0);
        settle();
        pop_expect("R5 first", 8'h12, 2'b01);
        pop_expect("R5 mid", 8'h34, 2'b00);
        pop_expect("R5 last", 8'h56, 2'b10);
        expect_empty("R5 fcs dropped");
        check("R8 none in frame", ga_cnt - ga0, 0);
    endtask

    task automatic t_stuff();  // R2
        pay[0] = 8'hFF; pay[1] = 8'h7E; pay[2] = 8'h3E; pay[3] = 8'hF8;
        send_frame(4, 1'b0, 0);
        settle();
        pop_expect("R2 b0", 8'hFF, 2'b01);
        pop_expect("R2 b1", 8'h7E, 2'b00);
        pop_expect("R2 b2", 8'h3E, 2'b00);
        pop_expect("R2 b3", 8'hF8, 2'b10);
        expect_empty("R2 end");
    endtask

    task automatic t_bad_fcs();  // R6
        pay[0] = 8'hA0; pay[1] = 8'hB1; pay[2] = 8'hC2;
        send_frame(3, 1'b1, 0);
        settle();
        pop_expect("R6 first", 8'hA0, 2'b01);
        pop_expect("R6 mid", 8'hB1, 2'b00);
        pop_expect("R6 last bad", 8'hC2, 2'b11);
        expect_empty("R6 end");
    endtask

    task automatic t_short();  // R3
        send_flag();
        send_byte(8'hA1); send_byte(8'hB2); send_byte(8'hC3);
        send_flag();
        settle();
        expect_empty("R3 24 bits");
    endtask

    task automatic t_mid_len();  // R4
        send_flag();
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
        send_stuffed(1'b1); send_stuffed(1'b0); send_stuffed(1'b1); send_stuffed(1'b0);
        send_flag();
        settle();
        pop_expect("R4 first", 8'h11, 2'b01);
        pop_expect("R4 mid", 8'h22, 2'b00);
        pop_expect("R4 last bad", 8'h33, 2'b11);
        expect_empty("R4 end");
    endtask

    task automatic t_abort();  // R7
        send_flag();
        send_byte(8'h55); send_byte(8'h0F); send_byte(8'h33); send_byte(8'h00);
        for (int i = 0; i < 8; i++) send_raw(1'b1);
        settle();
        pop_expect("R7 first", 8'h55, 2'b01);
        pop_expect("R7 mid", 8'h0F, 2'b00);
        pop_expect("R7 last bad", 8'h33, 2'b11);
        expect_empty("R7 end");
        send_flag();
        send_byte(8'hA5);
        for (int i = 0; i < 8; i++) send_raw(1'b1);
        settle();
        expect_empty("R7 short abort");
    endtask

    task automatic t_goahead();  // R8
        int ga0;
        ga0 = ga_cnt;
        send_raw(1'b0);
        for (int i = 0; i < 7; i++) send_raw(1'b1);
        send_raw(1'b0);
        settle();
        check("R8 one pulse", ga_cnt - ga0, 1);
    endtask

    task automatic t_idle();  // R9
        for (int i = 0; i < 14; i++) send_raw(1'b1);
        check("R9 14 ones", {31'd0, idle_line}, 32'd0);
        send_raw(1'b1);
        check("R9 15 ones", {31'd0, idle_line}, 32'd1);
        for (int i = 0; i < 5; i++) send_raw(1'b1);
        check("R9 stays", {31'd0, idle_line}, 32'd1);
        send_raw(1'b0);
        check("R9 zero clears", {31'd0, idle_line}, 32'd0);
    endtask

    task automatic t_gap();  // R12
        pay[0] = 8'h12; pay[1] = 8'h34; pay[2] = 8'h56;
        send_frame(3, 1'b0, 25);
        settle();
        pop_expect("R12 first", 8'h12, 2'b01);
        pop_expect("R12 mid", 8'h34, 2'b00);
        pop_expect("R12 last", 8'h56, 2'b10);
        expect_empty("R12 end");
    endtask

    task automatic t_rx_off();  // R11, R5 boundary at 32 bits
        send_flag();
        send_byte(8'h12); send_byte(8'h34);
        @(negedge clk) rx_en = 1'b0;
        send_byte(8'h56);
        for (int i = 0; i < 20; i++) send_raw(1'b1);
        check("R11 idle ignored", {31'd0, idle_line}, 32'd0);
        send_flag();
        settle();
        expect_empty("R11 dropped");
        @(negedge clk) rx_en = 1'b1;
        pay[0] = 8'h77; pay[1] = 8'h88;
        send_frame(2, 1'b0, 0);
        settle();
        pop_expect("R11 R5 32 bit first", 8'h77, 2'b01);
        pop_expect("R11 R5 32 bit last", 8'h88, 2'b10);
        expect_empty("R11 end");
    endtask

    task automatic t_overflow();  // R10
        check("R10 ovf before", {31'd0, fifo_ovf}, 32'd0);
        for (int i = 0; i < 20; i++) pay[i] = 8'h40 + 8'(i);
        send_frame(20, 1'b0, 0);
        settle();
        check("R10 ovf set", {31'd0, fifo_ovf}, 32'd1);
        pop_expect("R10 e0", 8'h40, 2'b01);
        for (int i = 1; i < 16; i++) pop_expect("R10 entry", 8'h40 + 8'(i), 2'b00);
        expect_empty("R10 16 deep");
        check("R10 ovf sticky", {31'd0, fifo_ovf}, 32'd1);
    endtask

    initial begin
        rst_n = 1'b0; rx_en = 1'b1; bit_vld = 1'b0; bit_in = 1'b0; rd_en = 1'b0;
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_pre_flag();
        t_good();
        t_stuff();
        t_bad_fcs();
        t_short();
        t_mid_len();
        t_abort();
        t_goahead();
        t_idle();
        t_gap();
        t_rx_off();
        t_overflow();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule